// File: doc/BRIEF.md
# Multi-channel prescaled PWM controller

This block drives a set of independent pulse-width-modulated outputs. Every channel is set up through a single 32-bit control word. The word holds a run bit, an 8-bit duty value and a 13-bit divider value. Software writes and reads these words over a simple register bus. The bus has an address, a write strobe, write data and combinational read data.

Each channel divides the system clock by (divider + 1) to make a tick. One output period lasts 256 ticks. The output is high for the first `duty` ticks of every period. Duty and divider changes written while a channel runs are held back until the current period ends, so no output pulse is ever cut short or stretched. Clearing the run bit drives the output low at once and parks both of the channel's counters at zero. Setting the run bit again starts a new period from tick 0.

Top module: `pwm_bank_top`

## Requirements
- R1: Bit 31 of a control word is the run bit. While it reads 0, the channel output is low and its tick and period counters stay at zero.
- R2: Bits 23:16 hold the duty D. In every period the output is high for exactly D ticks, and those are the first D ticks of the period.
- R3: Bits 12:0 hold the divider field P. One tick lasts P+1 clock cycles, and P = 0 gives one tick per clock.
- R4: One period lasts 256 ticks, which is 256·(P+1) clock cycles.
- R5: Channel n's word sits at byte address n·16. A write whose low four address bits are nonzero, or whose channel index is at least NUM_CH, changes nothing. A read from such an address returns 0.
- R6: The run, duty and divider fields read back exactly as written. Bits 30:24 and 15:13 always read 0.
- R7: Writing 0 to a channel word stops the channel and clears its duty and divider fields. The output is low from the cycle after the write.
- R8: With D = 0 the output never goes high. With D = 255 it is high for 255 of every 256 ticks.
- R9: Suppose a write sets the run bit at clock edge E. Then the output period starts at edge E+1 at tick 0. With D > 0, the output is high from that edge onward.
- R10: Duty or divider values written while a channel runs take effect only at the next period boundary.
- R11: Channels run independently of each other. NUM_CH defaults to 4 and may be set to 1.
- R12: After reset, every control word reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the control word |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench counts high cycles over windows aligned to the period. It covers duty values of 0, small, half and 255, each combined with dividers of 1, 2 and 3 cycles per tick.
- Comparing the high-cycle counts against D·(P+1) separates duty errors from divider errors.
- Zero and full-scale duty expose off-by-one errors at the ends of the period.
- A short window opened right after enabling, followed by an all-low remainder, checks the fresh start at tick 0.
- A duty change written in the middle of a period must leave the first period's count unchanged and alter only the second, which separates buffered updates from immediate ones.
- Writes to misaligned and out-of-range addresses, plus an all-ones write, confirm address decoding and the zero read-back of unused bits.

// File: rtl/pwm_bank_pkg.sv
// Package: pwm_bank_pkg
// Shared field layout and configuration type for the PWM controller.
// Assumes a 32-bit control word per channel and a 16-byte channel stride.
package pwm_bank_pkg;
    localparam int WORD_W     = 32;
    localparam int DUTY_W     = 8;
    localparam int DIV_W      = 13;
    localparam int RUN_BIT    = 31;
    localparam int DUTY_LSB   = 16;
    localparam int DIV_LSB    = 0;
    localparam int STRIDE_LSB = 4;

    typedef struct packed {
        logic              run;
        logic [DUTY_W-1:0] duty;
        logic [DIV_W-1:0]  div;
    } chan_cfg_t;

    // Build a bus word from a configuration; unused bits are zero.
    function automatic logic [WORD_W-1:0] cfg_to_word(input chan_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RUN_BIT]                   = c.run;
        w[DUTY_LSB +: DUTY_W]        = c.duty;
        w[DIV_LSB +: DIV_W]          = c.div;
        return w;
    endfunction

    // Extract the stored fields from a bus word; unused bits are dropped.
    function automatic chan_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.run  = w[RUN_BIT];
        c.duty = w[DUTY_LSB +: DUTY_W];
        c.div  = w[DIV_LSB +: DIV_W];
        return c;
    endfunction
endpackage

// File: rtl/pwm_reg_bank.sv
// Module: pwm_reg_bank
// Holds one control word per channel and decodes the register bus.
// Assumes word-aligned accesses at a 16-byte stride; any other address
// is ignored on write and reads as zero. Read data is combinational.
module pwm_reg_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output chan_cfg_t         cfg [NUM_CH]
);
    localparam int IDX_W = ADDR_W - STRIDE_LSB;

    logic             aligned;
    logic [IDX_W-1:0] idx;

    // Split the address into channel index and in-word offset.
    always_comb begin
        aligned = (bus_addr[STRIDE_LSB-1:0] == '0);
        idx     = bus_addr[ADDR_W-1:STRIDE_LSB];
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_word
        logic hit;
        assign hit = bus_we && aligned && (idx == IDX_W'(n));

        // Store the channel word on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg[n] <= '0;
            else if (hit)
                cfg[n] <= word_to_cfg(bus_wdata);
        end
    end

    // Return the addressed word, or zero for unmapped addresses.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (aligned && (idx == IDX_W'(i)))
                bus_rdata = cfg_to_word(cfg[i]);
        end
    end
endmodule

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Divides the clock by (div_val + 1) and pulses tick once per division.
// Assumes div_val is stable except right after a tick (period boundary).
module pwm_prescaler #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = !clear && (cnt == div_val);

    // Count clock cycles up to the divider value, then restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (cnt == div_val)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_channel.sv
// Module: pwm_channel
// One PWM channel: prescaler, 256-tick period counter and shadow copies
// of duty and divider that load only while idle or at a period boundary.
// Assumes cfg comes from registers in the clock domain of clk.
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  chan_cfg_t           cfg,
    output logic                pwm,
    output logic                active,
    output logic [DUTY_W-1:0]   act_duty,
    output logic [PERIOD_W-1:0] tick_cnt
);
    localparam logic [PERIOD_W-1:0] LAST_TICK = '1;

    logic             run_q;
    logic [DIV_W-1:0] act_div;
    logic             tick;

    assign active = run_q && cfg.run;
    assign pwm    = active && (tick_cnt < PERIOD_W'(act_duty));

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!active),
        .div_val (act_div),
        .tick    (tick)
    );

    // Delay the run bit one cycle so the shadows load before counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= cfg.run;
    end

    // Advance the period counter and reload shadows at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            act_duty <= '0;
            act_div  <= '0;
        end else if (!active) begin
            tick_cnt <= '0;
            act_duty <= cfg.duty;
            act_div  <= cfg.div;
        end else if (tick) begin
            tick_cnt <= tick_cnt + 1'b1;
            if (tick_cnt == LAST_TICK) begin
                act_duty <= cfg.duty;
                act_div  <= cfg.div;
            end
        end
    end
endmodule

// File: rtl/pwm_bank_top.sv
// Module: pwm_bank_top
// Multi-channel PWM controller: register bank plus NUM_CH channels.
// Assumes synchronous active-low reset and a single clock domain.
module pwm_bank_top
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int PERIOD_W = 8;

    chan_cfg_t                  cfg [NUM_CH];
    logic [NUM_CH-1:0]          cfg_run;
    logic [NUM_CH-1:0]          ch_active;
    logic [NUM_CH*DUTY_W-1:0]   ch_duty;
    logic [NUM_CH*PERIOD_W-1:0] ch_tick;

    pwm_reg_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign cfg_run[n] = cfg[n].run;

        pwm_channel #(.PERIOD_W(PERIOD_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (cfg[n]),
            .pwm      (pwm_out[n]),
            .active   (ch_active[n]),
            .act_duty (ch_duty[n*DUTY_W +: DUTY_W]),
            .tick_cnt (ch_tick[n*PERIOD_W +: PERIOD_W])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
// Module: pwm_bank_chk
// Property checker bound to pwm_bank_top.
module pwm_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_CH-1:0]   pwm_out,
    input logic [NUM_CH-1:0]   cfg_run,
    input logic [NUM_CH-1:0]   ch_active,
    input logic [NUM_CH*8-1:0] ch_duty,
    input logic [NUM_CH*8-1:0] ch_tick
);
    AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[30:24] == 7'd0) && (bus_rdata[15:13] == 3'd0)); // R6

    for (genvar n = 0; n < NUM_CH; n++) begin : g_p
        AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_run[n] |-> !pwm_out[n]); // R1

        AST_ZERO_WRITE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_wdata == 32'd0 && bus_addr[3:0] == 4'd0
             && bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(n)) |=> !pwm_out[n]); // R7

        AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_active[n] && ch_duty[n*8 +: 8] == 8'd0) |-> !pwm_out[n]); // R8

        AST_UPDATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ch_active[n]) && ch_active[n] && !$stable(ch_duty[n*8 +: 8]))
            |-> (ch_tick[n*8 +: 8] == 8'd0 && $past(ch_tick[n*8 +: 8]) == 8'hFF)); // R10
    end
endmodule

bind pwm_bank_top pwm_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .cfg_run   (cfg_run),
    .ch_active (ch_active),
    .ch_duty   (ch_duty),
    .ch_tick   (ch_tick)
);

// File: tb/pwm_bank_top_tb_top.sv
// Scoreboard bench: the driver queues expected high-cycle counts per
// window, and the monitor counts pwm_out samples and compares them.
module pwm_bank_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int    ch;
        int    win;
        int    exp_hi;
        string req;
    } item_t;

    item_t q[$];
    bit    mon_busy = 1'b0;

    always #10 clk = ~clk;

    pwm_bank_top #(.NUM_CH(4), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
    endtask

    task automatic expect_high(input int ch, input int win, input int exp_hi, input string req);
        item_t it;
        it.ch = ch; it.win = win; it.exp_hi = exp_hi; it.req = req;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0 && !mon_busy);
    endtask

    // Monitor: count high samples over each queued window and compare.
    initial begin
        forever begin
            item_t it;
            int    hi;
            wait (q.size() != 0);
            mon_busy = 1'b1;
            it = q.pop_front();
            hi = 0;
            for (int i = 0; i < it.win; i++) begin
                @(negedge clk);
                if (pwm_out[it.ch]) hi++;
            end
            check(it.req, hi, it.exp_hi);
            mon_busy = 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        read_chk(8'h00, 32'h0, "R12 ch0 word");
        read_chk(8'h30, 32'h0, "R12 ch3 word");
        check("R12 outputs low", pwm_out, 0);

        // R6: all-ones write reads back only the implemented fields
        bus_write(8'h10, 32'hFFFF_FFFF);
        read_chk(8'h10, 32'h80FF_1FFF, "R6 readback");
        // R7: writing zero stops and clears
        bus_write(8'h10, 32'h0);
        read_chk(8'h10, 32'h0, "R7 cleared word");
        expect_high(1, 16, 0, "R7 output low");
        drain();

        // R5: stride and ignored addresses
        bus_write(8'h30, 32'h0033_0044);
        read_chk(8'h30, 32'h0033_0044, "R5 ch3 at 0x30");
        bus_write(8'h14, 32'h8012_0003);
        read_chk(8'h10, 32'h0, "R5 misaligned write ignored");
        read_chk(8'h14, 32'h0, "R5 misaligned read zero");
        expect_high(1, 64, 0, "R5 ch1 stays low");
        drain();
        bus_write(8'h40, 32'h8012_0003);
        read_chk(8'h40, 32'h0, "R5 out-of-range read zero");
        bus_write(8'h30, 32'h0);

        // R2: duty 64, divider 0
        bus_write(8'h00, 32'h8040_0000);
        expect_high(0, 256, 64, "R2 duty 64 period 1");
        expect_high(0, 256, 64, "R4 duty 64 period 2");
        drain();

        // R8: duty 0 never high
        bus_write(8'h00, 32'h0);
        bus_write(8'h00, 32'h8000_0000);
        expect_high(0, 256, 0, "R8 duty 0");
        drain();

        // R8/R3: duty 255, divider field 1
        bus_write(8'h30, 32'h80FF_0001);
        expect_high(3, 512, 510, "R8 duty 255 div 2");
        drain();

        // R3/R11: ch1 duty 128 divider 2 while ch0 also runs
        bus_write(8'h00, 32'h0);
        bus_write(8'h00, 32'h8020_0000);
        bus_write(8'h10, 32'h8080_0002);
        expect_high(1, 768, 384, "R3 duty 128 div 3");
        drain();
        expect_high(0, 256, 32, "R11 ch0 independent");
        drain();

        // R1: duty set but run bit clear
        bus_write(8'h20, 32'h0080_0000);
        expect_high(2, 256, 0, "R1 disabled channel");
        drain();

        // R10: duty change mid-period waits for the boundary
        bus_write(8'h20, 32'h800A_0000);
        expect_high(2, 256, 10, "R10 old duty kept");
        expect_high(2, 256, 200, "R10 new duty next period");
        repeat (50) @(negedge clk);
        bus_write(8'h20, 32'h80C8_0000);
        drain();

        // R9: stop mid-period, restart begins at tick 0
        repeat (37) @(negedge clk);
        bus_write(8'h20, 32'h0);
        bus_write(8'h20, 32'h8005_0000);
        expect_high(2, 5, 5, "R9 high from first tick");
        expect_high(2, 251, 0, "R9 low for rest of period");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule